// File: doc/BRIEF.md
# Hall Sensor Six-Step Commutation Decoder

This block turns the three-bit state of a set of rotor position sensors into the six gate enables of a three-phase bridge. The enables go on to a PWM masking stage. The three bits come either from the hardware sensor pins, which are assumed to be already filtered, or from three bits that firmware writes. A select input picks the source.

A programmable table of twelve 6-bit patterns sets which bridge arms each valid sensor state turns on. Six patterns serve forward rotation and six serve reverse rotation. The table is loaded through a simple write port.

Priority overrides sit on top of the lookup, in this order from strongest to weakest:
- a disable input and a protect input switch every arm off;
- a coast control lets the motor spin freely;
- a brake control shorts the windings through the low-side arms.

Sensor states that cannot occur on a healthy motor (all zeros, all ones) switch the bridge off and latch an error flag. The gate pattern is registered, so it follows a change of the sensor state after one clock.

Top module: `hall_comm_decoder`

## Requirements
- R1: While `rst_n` is low, `gate_en` and `hall_err` are 0, asynchronously, and every table entry is cleared to 6'b000000.
- R2: The selected sensor code is `hall_sw` when `src_sw` is 1 and `hall_hw` when `src_sw` is 0. The source that is not selected has no effect on the outputs.
- R3: With `dir_rev`=0, a valid code c (1 to 6) drives `gate_en` with table entry c-1. `gate_en` bit order is [5]=A high, [4]=A low, [3]=B high, [2]=B low, [1]=C high, [0]=C low.
- R4: With `dir_rev`=1, a valid code c drives `gate_en` with table entry c+5, which is entries 6 to 11.
- R5: `gate_en` is registered. It changes on the first rising clock edge after its inputs change, and not before that edge.
- R6: Codes 0 and 7 drive `gate_en` to 6'b000000. When such a code is seen with `dec_en`=1 and `protect`=0, `hall_err` goes to 1 on the next edge, even while brake or coast is active.
- R7: `hall_err` stays at 1 until a cycle with `clr_err`=1. If a new error is set in the same cycle as the clear, the set wins.
- R8: With `brake`=1, `gate_en` is 6'b010101 (all low arms on, all high arms off). This overrides the direction and invalid codes.
- R9: With `coast`=1, `gate_en` is 6'b000000. This overrides brake.
- R10: With `dec_en`=0 or `protect`=1, `gate_en` is 6'b000000 and `hall_err` is not set. This overrides everything else.
- R11: A write with `tbl_we`=1 stores `tbl_wdata` at entry `tbl_addr` (0 to 11) on the clock edge. The lookup uses the new value from the following edge onward. Writes to addresses 12 to 15 change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Decoder enable |
| protect | input | 1 | Protection shutdown, forces all arms off |
| src_sw | input | 1 | 1: use software sensor bits, 0: use hardware sensor pins |
| hall_hw | input | 3 | Filtered hardware sensor state |
| hall_sw | input | 3 | Software sensor state |
| dir_rev | input | 1 | 0: forward table set, 1: reverse table set |
| brake | input | 1 | Brake through the low-side arms |
| coast | input | 1 | Free-run, all arms off |
| clr_err | input | 1 | Clear the sticky invalid-state flag |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry address |
| tbl_wdata | input | 6 | Gate pattern to store |
| gate_en | output | 6 | Registered bridge arm enables |
| hall_err | output | 1 | Sticky invalid sensor state flag |

## Verification
The assertions check the override ladder on every cycle: shutdown, coast, brake and invalid codes each force a known pattern one edge later. They also check that the error flag is set, held and cleared as specified. The table contents cannot be seen at the ports, so only the bench scenarios can show the following:
- each valid code in each direction picks the right entry;
- writes to unused addresses are dropped;
- a table write takes effect with the correct latency;
- the source that is not selected is ignored.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;
  localparam int HALL_W  = 3;
  localparam int PHASES  = 3;
  localparam int GATE_W  = 2 * PHASES;
  localparam int STEPS   = 6;
  localparam int ENTRIES = 2 * STEPS;
  localparam int ADDR_W  = $clog2(ENTRIES) + ((2 ** $clog2(ENTRIES)) == ENTRIES ? 1 : 0);

  typedef logic [GATE_W-1:0] gate_t;
  typedef logic [HALL_W-1:0] hall_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Brake pattern: for every phase pair {high, low}, low arm on, high arm off
  function automatic gate_t low_side_all();
    gate_t g;
    for (int p = 0; p < PHASES; p++) begin
      g[2*p+1] = 1'b0;
      g[2*p]   = 1'b1;
    end
    return g;
  endfunction
endpackage

// File: rtl/hall_rst_sync.sv
module hall_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hall_src_mux.sv
module hall_src_mux
  import hall_comm_pkg::*;
(
  input  logic  src_sw,
  input  hall_t hall_hw,
  input  hall_t hall_sw,
  input  logic  dir_rev,
  output logic  code_ok,
  output addr_t rd_idx
);
  hall_t code;
  addr_t base;

  always_comb begin
    code    = src_sw ? hall_sw : hall_hw;
    code_ok = (code != '0) && (code != {HALL_W{1'b1}});
    base    = dir_rev ? addr_t'(STEPS) : '0;
    if (code_ok) rd_idx = base + addr_t'(code) - addr_t'(1);
    else         rd_idx = '0;
  end
endmodule

// File: rtl/hall_comm_table.sv
module hall_comm_table
  import hall_comm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  gate_t wr_data,
  input  addr_t rd_addr,
  output gate_t rd_data
);
  logic [ENTRIES*GATE_W-1:0] tbl_flat;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic  hit;
      gate_t ent_q;
      always_comb hit = wr_en && (wr_addr == addr_t'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ent_q <= '0;
        else if (hit) ent_q <= wr_data;
      end
      assign tbl_flat[e*GATE_W +: GATE_W] = ent_q;
    end
  endgenerate

  always_comb begin
    if (int'(rd_addr) < ENTRIES) rd_data = tbl_flat[int'(rd_addr)*GATE_W +: GATE_W];
    else                         rd_data = '0;
  end
endmodule

// File: rtl/hall_gate_ctrl.sv
module hall_gate_ctrl
  import hall_comm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dec_en,
  input  logic  protect,
  input  logic  coast,
  input  logic  brake,
  input  logic  code_ok,
  input  gate_t tbl_pat,
  input  logic  clr_err,
  output gate_t gate_q,
  output logic  err_q
);
  gate_t gate_d;
  logic  err_d;
  logic  live;

  always_comb begin
    live = dec_en && !protect;
    if (!live)         gate_d = '0;
    else if (coast)    gate_d = '0;
    else if (brake)    gate_d = low_side_all();
    else if (!code_ok) gate_d = '0;
    else               gate_d = tbl_pat;

    if (live && !code_ok) err_d = 1'b1;
    else if (clr_err)     err_d = 1'b0;
    else                  err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      err_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/hall_comm_decoder.sv
module hall_comm_decoder
  import hall_comm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic              protect,
  input  logic              src_sw,
  input  logic [HALL_W-1:0] hall_hw,
  input  logic [HALL_W-1:0] hall_sw,
  input  logic              dir_rev,
  input  logic              brake,
  input  logic              coast,
  input  logic              clr_err,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [GATE_W-1:0] tbl_wdata,
  output logic [GATE_W-1:0] gate_en,
  output logic              hall_err
);
  logic  rst_sync_n;
  logic  code_ok;
  addr_t rd_idx;
  gate_t tbl_pat;

  hall_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hall_src_mux u_mux (
    .src_sw(src_sw), .hall_hw(hall_hw), .hall_sw(hall_sw),
    .dir_rev(dir_rev), .code_ok(code_ok), .rd_idx(rd_idx)
  );

  hall_comm_table u_tbl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
    .wr_data(tbl_wdata), .rd_addr(rd_idx), .rd_data(tbl_pat)
  );

  hall_gate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .dec_en(dec_en), .protect(protect),
    .coast(coast), .brake(brake), .code_ok(code_ok), .tbl_pat(tbl_pat),
    .clr_err(clr_err), .gate_q(gate_en), .err_q(hall_err)
  );
endmodule

// File: rtl/hall_comm_decoder_chk.sv
module hall_comm_decoder_chk
  import hall_comm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        dec_en,
  input logic        protect,
  input logic        src_sw,
  input logic [2:0]  hall_hw,
  input logic [2:0]  hall_sw,
  input logic        brake,
  input logic        coast,
  input logic        clr_err,
  input logic [5:0]  gate_en,
  input logic        hall_err
);
  logic [2:0] sel;
  logic       bad;
  always_comb begin
    sel = src_sw ? hall_sw : hall_hw;
    bad = (sel == 3'd0) || (sel == 3'd7);
  end

  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en || protect) |=> (gate_en == 6'b000000)); // R10
  AST_SHUTDOWN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dec_en || protect) && !hall_err) |=> !hall_err); // R10
  AST_COAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !protect && coast) |=> (gate_en == 6'b000000)); // R9
  AST_BRAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !protect && !coast && brake) |=> (gate_en == 6'b010101)); // R8
  AST_INVALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !protect && !coast && !brake && bad) |=> (gate_en == 6'b000000)); // R6
  AST_INVALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !protect && bad) |=> hall_err); // R6
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_err && !clr_err) |=> hall_err); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !(dec_en && !protect && bad)) |=> !hall_err); // R7
endmodule

bind hall_comm_decoder hall_comm_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .dec_en(dec_en), .protect(protect),
  .src_sw(src_sw), .hall_hw(hall_hw), .hall_sw(hall_sw), .brake(brake),
  .coast(coast), .clr_err(clr_err), .gate_en(gate_en), .hall_err(hall_err)
);

// File: tb/hall_comm_decoder_tb.sv
module hall_comm_decoder_tb;
  logic       clk;
  logic       rst_n;
  logic       dec_en, protect, src_sw, dir_rev, brake, coast, clr_err, tbl_we;
  logic [2:0] hall_hw, hall_sw;
  logic [3:0] tbl_addr;
  logic [5:0] tbl_wdata;
  logic [5:0] gate_en;
  logic       hall_err;
  int         total = 0;
  int         bad   = 0;

  hall_comm_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .protect(protect), .src_sw(src_sw),
    .hall_hw(hall_hw), .hall_sw(hall_sw), .dir_rev(dir_rev), .brake(brake),
    .coast(coast), .clr_err(clr_err), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .gate_en(gate_en), .hall_err(hall_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [5:0] PAT [12] = '{
    6'b100100, 6'b100001, 6'b001001, 6'b011000, 6'b010010, 6'b000110,
    6'b110000, 6'b001100, 6'b000011, 6'b101000, 6'b100010, 6'b001010};

  // {src_sw, hall_hw, hall_sw, dir_rev, brake, coast, dec_en, protect, clr_err, exp_gate, exp_err}
  localparam int NV = 23;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0,3'd1,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b100100,1'b0}, // R3
    {1'b0,3'd2,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b100001,1'b0}, // R3
    {1'b0,3'd3,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b001001,1'b0}, // R3
    {1'b0,3'd4,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b011000,1'b0}, // R3
    {1'b0,3'd5,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b010010,1'b0}, // R3
    {1'b0,3'd6,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b000110,1'b0}, // R3
    {1'b0,3'd1,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,6'b110000,1'b0}, // R4
    {1'b0,3'd6,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,6'b001010,1'b0}, // R4
    {1'b0,3'd3,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,6'b000011,1'b0}, // R4
    {1'b1,3'd2,3'd5,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b010010,1'b0}, // R2
    {1'b0,3'd2,3'd5,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b100001,1'b0}, // R2
    {1'b0,3'd3,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,6'b010101,1'b0}, // R8
    {1'b0,3'd3,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,6'b000000,1'b0}, // R9
    {1'b0,3'd1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000000,1'b0}, // R10
    {1'b0,3'd1,3'd0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,6'b000000,1'b0}, // R10
    {1'b0,3'd0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b000000,1'b1}, // R6
    {1'b0,3'd4,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'b011000,1'b1}, // R7
    {1'b0,3'd4,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,6'b011000,1'b0}, // R7
    {1'b0,3'd7,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,6'b000000,1'b1}, // R7
    {1'b0,3'd2,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,6'b100001,1'b0}, // R7
    {1'b0,3'd7,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000000,1'b0}, // R10
    {1'b0,3'd0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,6'b010101,1'b1}, // R8
    {1'b0,3'd1,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,6'b100100,1'b0}  // R3
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [19:0] v);
    src_sw = v[19]; hall_hw = v[18:16]; hall_sw = v[15:13]; dir_rev = v[12];
    brake = v[11]; coast = v[10]; dec_en = v[9]; protect = v[8]; clr_err = v[7];
  endtask

  task automatic wr(input logic [3:0] a, input logic [5:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic look(input logic [2:0] code, input logic rev, input logic [5:0] exp, input string req);
    @(negedge clk);
    drive({1'b0, code, 3'd0, rev, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0});
    @(negedge clk);
    chk(req, gate_en, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    drive({1'b0,3'd1,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,7'd0});
    repeat (3) @(negedge clk);
    chk("R1 gate", gate_en, 6'b000000);
    chk("R1 err", {5'd0, hall_err}, 6'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 table clear", gate_en, 6'b000000); // code 1 reads cleared entry
    for (int e = 0; e < 12; e++) wr(4'(e), PAT[e]);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("vec%0d gate", i), gate_en, VEC[i][6:1]);
      chk($sformatf("vec%0d err", i), {5'd0, hall_err}, {5'd0, VEC[i][0]});
    end

    // R5: no change before the edge, new value right after it
    @(negedge clk);
    drive({1'b0,3'd2,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,7'd0});
    #1 chk("R5 before edge", gate_en, 6'b100100);
    @(posedge clk); #2;
    chk("R5 after edge", gate_en, 6'b100001);

    // R11: writes above entry 11 are dropped
    for (int a = 12; a < 16; a++) wr(4'(a), 6'b111111);
    for (int c = 1; c < 7; c++) begin
      look(3'(c), 1'b0, PAT[c-1], "R11 fwd kept");
      look(3'(c), 1'b1, PAT[c+5], "R11 rev kept");
    end

    // R11: write latency on a live entry
    look(3'd5, 1'b0, PAT[4], "R11 pre");
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'd4; tbl_wdata = 6'b111000;
    @(negedge clk);
    tbl_we = 1'b0;
    chk("R11 old on write edge", gate_en, PAT[4]);
    @(negedge clk);
    chk("R11 new next edge", gate_en, 6'b111000);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 chk("R1 async gate", gate_en, 6'b000000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 table cleared", gate_en, 6'b000000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule